// File: doc/BRIEF.md
# Register Lock Scoreboard with Operand Forwarding

This block is the hazard unit of a simple in-order pipeline. It keeps a lock flag for every architectural register. An instruction that writes a result sets the flag of its destination when it issues, and the flag drops when that result comes back on the write-back bus. A younger instruction that reads a locked register is held at issue, unless its operand can be taken from a bypass. There are two bypasses: the ALU output of the instruction now in execute, and the result now on the write-back bus.

Loads are the case a bypass cannot always cover. A load in execute has only an address on the ALU output. Its consumers stay held until the load's data reaches the write-back bus, and from that cycle they can take it from the bus.

Issue is a valid/stall handshake. The issue stage presents `iss_vld` with its register indices. An instruction is accepted on a clock edge where `iss_vld` is high and `iss_stall` is low. While stalled, the stage must hold its request unchanged, and nothing in the block changes on its behalf. `iss_stall` and the operand selects are combinational functions of the current inputs and the lock flags. A change to a lock flag shows from the cycle after the edge that caused it.

Top module: `regfile_hazard_unit`

## Requirements
- R1: After reset every lock flag is clear, so a read of any register is not stalled and selects the register file.
- R2: An accepted issue with `iss_wr` high and a nonzero `iss_rd` locks that register. A later read of it stalls when neither bypass matches.
- R3: A write-back (`wb_vld` with `wb_tag`) clears that register's lock, from the next cycle on, when no issue sets the same register in the same cycle.
- R4: A source that is locked and equals `ex_tag` while `ex_vld` is high and `ex_is_load` is low selects the ALU (select code 01) and does not stall. A source that is not locked selects the register file (00) even when tags match.
- R5: A source that is locked and equals `wb_tag` while `wb_vld` is high selects the write-back bus (select code 10) and does not stall.
- R6: When `ex_is_load` is high, the ALU bypass is not offered. A locked source that matches only `ex_tag` stalls.
- R7: When both bypasses match a locked source, the ALU (01) is selected.
- R8: Register 0 is never locked. A source index of 0 never stalls and always selects the register file (00).
- R9: When an issue locks a register in the same cycle that a write-back clears it, the register ends up locked.
- R10: A producing issue whose destination is locked stalls, unless a write-back to that same register happens in the same cycle.
- R11: Reads never lock anything. An instruction with `iss_wr` low leaves its registers usable, and two reads of one register do not stall.
- R12: `iss_stall` is low whenever `iss_vld` is low. A stalled issue does not lock its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_vld | input | 1 | Issue request valid |
| iss_wr | input | 1 | Instruction writes a destination register |
| iss_rd | input | IDXW | Destination register index |
| iss_rs_a | input | IDXW | First source register index |
| iss_rs_b | input | IDXW | Second source register index |
| iss_stall | output | 1 | Issue must be held this cycle |
| op_sel_a | output | 2 | First operand source: 00 register file, 01 ALU, 10 write-back bus |
| op_sel_b | output | 2 | Second operand source, same code |
| ex_vld | input | 1 | An instruction with a destination is in execute |
| ex_is_load | input | 1 | The instruction in execute is a load |
| ex_tag | input | IDXW | Destination of the instruction in execute |
| wb_vld | input | 1 | A result is on the write-back bus |
| wb_tag | input | IDXW | Destination of the write-back result |

## Verification
The stall and select outputs are due in the same cycle as the inputs that cause them. Each check drives its inputs after a falling edge and samples 5 ns later, before the next rising edge. Lock changes are due one edge later. The bench therefore proves a lock set or clear only with a read driven in a following cycle. Same-cycle set/clear and the WAW hold-off are checked over back-to-back cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OPS_RF  = 2'b00,
    OPS_ALU = 2'b01,
    OPS_WB  = 2'b10
  } opsel_e;
endpackage

// File: rtl/sb_lock_table.sv
module sb_lock_table #(
  parameter int NREG = 32,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IDXW-1:0] set_idx,
  input  logic            clr_en,
  input  logic [IDXW-1:0] clr_idx,
  output logic [NREG-1:0] locked
);
  // one flag per register; register 0 is hardwired clear
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign locked[g] = 1'b0;
    end else begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 locked[g] <= 1'b0;
        else if (set_en && set_idx == IDXW'(g))     locked[g] <= 1'b1; // set wins
        else if (clr_en && clr_idx == IDXW'(g))     locked[g] <= 1'b0;
      end
    end
  end

  // R2
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_idx != '0) |=> locked[$past(set_idx)]);

  // R3
  lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !locked[$past(clr_idx)]);
endmodule

// File: rtl/sb_src_resolve.sv
module sb_src_resolve
  import sb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] src_idx,
  input  logic [NREG-1:0] locked,
  input  logic            alu_ok,
  input  logic [IDXW-1:0] ex_tag,
  input  logic            wb_vld,
  input  logic [IDXW-1:0] wb_tag,
  output opsel_e          sel,
  output logic            blocked
);
  logic src_locked;
  assign src_locked = (src_idx != '0) && locked[src_idx];

  always_comb begin
    sel     = OPS_RF;
    blocked = 1'b0;
    if (src_locked) begin
      if (alu_ok && ex_tag == src_idx)      sel = OPS_ALU;
      else if (wb_vld && wb_tag == src_idx) sel = OPS_WB;
      else                                  blocked = 1'b1;
    end
  end

  // R2
  blocked_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> locked[src_idx]);

  // R8
  zero_src_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx == '0) |-> (!blocked && sel == OPS_RF));
endmodule

// File: rtl/sb_issue_gate.sv
module sb_issue_gate #(
  parameter int NREG = 32,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            iss_vld,
  input  logic            iss_wr,
  input  logic [IDXW-1:0] iss_rd,
  input  logic [1:0]      src_blocked,
  input  logic [NREG-1:0] locked,
  input  logic            wb_vld,
  input  logic [IDXW-1:0] wb_tag,
  output logic            stall,
  output logic            set_en
);
  logic dst_busy, waw_hold;
  assign dst_busy = iss_wr && (iss_rd != '0) && locked[iss_rd];
  assign waw_hold = dst_busy && !(wb_vld && wb_tag == iss_rd);
  assign stall    = iss_vld && ((|src_blocked) || waw_hold);
  assign set_en   = iss_vld && !stall && iss_wr && (iss_rd != '0);
endmodule

// File: rtl/regfile_hazard_unit.sv
module regfile_hazard_unit
  import sb_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IDXW = $clog2(NREG),
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_vld,
  input  logic            iss_wr,
  input  logic [IDXW-1:0] iss_rd,
  input  logic [IDXW-1:0] iss_rs_a,
  input  logic [IDXW-1:0] iss_rs_b,
  output logic            iss_stall,
  output logic [1:0]      op_sel_a,
  output logic [1:0]      op_sel_b,
  input  logic            ex_vld,
  input  logic            ex_is_load,
  input  logic [IDXW-1:0] ex_tag,
  input  logic            wb_vld,
  input  logic [IDXW-1:0] wb_tag
);
  logic [NREG-1:0] locked;
  logic            set_en, alu_ok;
  logic [IDXW-1:0] src_idx [NSRC];
  opsel_e          src_sel [NSRC];
  logic [NSRC-1:0] src_blk;

  assign alu_ok     = ex_vld && !ex_is_load;
  assign src_idx[0] = iss_rs_a;
  assign src_idx[1] = iss_rs_b;

  sb_lock_table #(.NREG(NREG), .IDXW(IDXW)) u_locks (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_idx(iss_rd),
    .clr_en(wb_vld), .clr_idx(wb_tag),
    .locked(locked)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    sb_src_resolve #(.NREG(NREG), .IDXW(IDXW)) u_res (
      .clk(clk), .rst_n(rst_n),
      .src_idx(src_idx[s]), .locked(locked),
      .alu_ok(alu_ok), .ex_tag(ex_tag),
      .wb_vld(wb_vld), .wb_tag(wb_tag),
      .sel(src_sel[s]), .blocked(src_blk[s])
    );
  end

  sb_issue_gate #(.NREG(NREG), .IDXW(IDXW)) u_gate (
    .iss_vld(iss_vld), .iss_wr(iss_wr), .iss_rd(iss_rd),
    .src_blocked(src_blk), .locked(locked),
    .wb_vld(wb_vld), .wb_tag(wb_tag),
    .stall(iss_stall), .set_en(set_en)
  );

  assign op_sel_a = src_sel[0];
  assign op_sel_b = src_sel[1];

  // R12
  no_idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_vld |-> !iss_stall);

  // R6
  alu_fwd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel_a == 2'b01 || op_sel_b == 2'b01) |-> (ex_vld && !ex_is_load));

  // R5
  wb_fwd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel_a == 2'b10 || op_sel_b == 2'b10) |-> wb_vld);
endmodule

// File: tb/regfile_hazard_unit_tb_top.sv
module regfile_hazard_unit_tb_top;
  localparam int IDXW = 5;
  localparam int NV   = 21;

  typedef struct packed {
    logic       iv, wr;
    logic [4:0] rd, ra, rb;
    logic       exv, exl;
    logic [4:0] ext;
    logic       wbv;
    logic [4:0] wbt;
    logic       stall;
    logic [1:0] sa, sb;
    logic [3:0] req;
  } vec_t;

  // iv wr rd ra rb exv exl ext wbv wbt | stall sa sb | req
  localparam vec_t VECS [NV] = '{
    '{1,1, 5, 1, 2, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd2},  // R2 lock r5
    '{1,1, 6, 5, 3, 0,0, 0, 0, 0, 1,2'd0,2'd0, 4'd2},  // R2 r5 read stalls
    '{1,0, 0, 5, 3, 1,0, 5, 0, 0, 0,2'd1,2'd0, 4'd4},  // R4 ALU bypass
    '{1,0, 0, 5, 3, 1,1, 5, 0, 0, 1,2'd0,2'd0, 4'd6},  // R6 load in ex
    '{1,0, 0, 3, 5, 0,0, 0, 1, 5, 0,2'd0,2'd2, 4'd5},  // R5 bus bypass, clears r5
    '{1,0, 0, 5, 6, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd12}, // R3 r5 free, R12 r6 never locked
    '{1,1, 7, 0, 0, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd2},  // lock r7
    '{1,0, 0, 7, 7, 1,0, 7, 1, 7, 0,2'd1,2'd1, 4'd7},  // R7 ALU over bus
    '{1,0, 0, 7, 0, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd3},  // R3 r7 cleared
    '{1,1, 0, 0, 0, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd8},  // R8 write to r0
    '{1,0, 0, 0, 0, 1,0, 0, 1, 0, 0,2'd0,2'd0, 4'd8},  // R8 r0 unlocked
    '{1,0, 9, 9, 9, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd11}, // R11 read only
    '{1,0, 0, 9, 9, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd11}, // R11 RAR no stall
    '{1,1,12, 0, 0, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd2},  // lock r12
    '{1,1,12, 0, 0, 0,0, 0, 0, 0, 1,2'd0,2'd0, 4'd10}, // R10 WAW holds
    '{1,1,12, 0, 0, 0,0, 0, 1,12, 0,2'd0,2'd0, 4'd10}, // R10 WAW freed by wb
    '{1,0, 0,12, 0, 0,0, 0, 0, 0, 1,2'd0,2'd0, 4'd9},  // R9 set won
    '{0,0, 0, 0, 0, 0,0, 0, 1,12, 0,2'd0,2'd0, 4'd12}, // R12 idle, clears r12
    '{1,0, 0,12, 0, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd3},  // R3 r12 free
    '{1,0, 0, 3, 0, 1,0, 3, 1, 3, 0,2'd0,2'd0, 4'd4},  // R4 unlocked -> regfile
    '{0,0, 0, 0, 0, 0,0, 0, 0, 0, 0,2'd0,2'd0, 4'd12}  // R12 idle
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_vld, iss_wr, ex_vld, ex_is_load, wb_vld, iss_stall;
  logic [IDXW-1:0] iss_rd, iss_rs_a, iss_rs_b, ex_tag, wb_tag;
  logic [1:0] op_sel_a, op_sel_b;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regfile_hazard_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_wr(iss_wr), .iss_rd(iss_rd),
    .iss_rs_a(iss_rs_a), .iss_rs_b(iss_rs_b),
    .iss_stall(iss_stall), .op_sel_a(op_sel_a), .op_sel_b(op_sel_b),
    .ex_vld(ex_vld), .ex_is_load(ex_is_load), .ex_tag(ex_tag),
    .wb_vld(wb_vld), .wb_tag(wb_tag)
  );

  task automatic chk(string what, int req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    @(negedge clk);
    iss_vld = v.iv; iss_wr = v.wr; iss_rd = v.rd;
    iss_rs_a = v.ra; iss_rs_b = v.rb;
    ex_vld = v.exv; ex_is_load = v.exl; ex_tag = v.ext;
    wb_vld = v.wbv; wb_tag = v.wbt;
    #5;
  endtask

  function automatic vec_t mk(logic iv, logic wr, logic [4:0] rd, logic [4:0] ra);
    vec_t v = '0;
    v.iv = iv; v.wr = wr; v.rd = rd; v.ra = ra;
    return v;
  endfunction

  initial begin
    drive('0);
    // R1 reset state, while reset held
    drive(mk(1, 0, 0, 5));
    chk("stall in reset", 1, {1'b0, iss_stall}, 2'd0);
    chk("sel in reset", 1, op_sel_a, 2'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk($sformatf("row %0d stall", i), int'(VECS[i].req), {1'b0, iss_stall}, {1'b0, VECS[i].stall});
      chk($sformatf("row %0d sel_a", i), int'(VECS[i].req), op_sel_a, VECS[i].sa);
      chk($sformatf("row %0d sel_b", i), int'(VECS[i].req), op_sel_b, VECS[i].sb);
    end

    // R1 reset clears a live lock
    drive(mk(1, 1, 4, 0));
    drive(mk(1, 0, 0, 4));
    chk("r4 locked before reset", 2, {1'b0, iss_stall}, 2'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(mk(1, 0, 0, 4));
    chk("r4 free after reset", 1, {1'b0, iss_stall}, 2'd0);
    chk("r4 sel after reset", 1, op_sel_a, 2'd0);
    drive('0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule